// File: doc/BRIEF.md
# Byte-Serial RGB LCD Timing Generator

This block drives an 8-bit parallel LCD port that carries one colour byte per clock, so a 24-bit pixel takes three port clocks. It produces an active-low horizontal sync, an active-low vertical sync and a data-enable that marks the valid pixel window in each line. Pixel data comes in as 16-bit words on a ready/valid stream. Each word is split into two byte beats on the port, with the low byte first.

The raster is built from two counters with the same structure. The vertical counter starts one clock after `en` is sampled high. The horizontal counter starts one clock later, so vertical sync always falls one clock before the first horizontal sync. Vertical sync is measured in whole line periods. The data window opens a fixed number of clocks after each horizontal sync begins, and only on lines that follow the blanking lines. A word missing from the stream at an active data clock sets a sticky underflow flag and blanks that word's two beats. Dropping `en` stops both counters and returns the syncs to their idle level. All timing constants are parameters.

Top module: `lcd_serial_tgen`

## Requirements
- R1: After `en` is sampled high at a clock edge, `lcd_vs_n` is low from that edge onward. `lcd_hs_n` stays high for exactly one more clock, then falls, so VS leads HS by one clock.
- R2: Counting from its first fall, `lcd_hs_n` is low for the first HS_CLKS clocks of every horizontal period of LINE_PIX*CLK_PER_PIX clocks and high for the rest.
- R3: `lcd_vs_n` is low for the first VS_LINES whole horizontal periods of every frame and high for the rest. A frame is (BLANK_LINES+ACTIVE_LINES) horizontal periods long.
- R4: `lcd_de` is high only at horizontal positions DATA_DELAY to DATA_DELAY+ACT_PIX*CLK_PER_PIX-1, counted from the first clock of HS low, and only on line indices BLANK_LINES and above. Line 0 is the first line of a frame.
- R5: During the data window a word is taken on the even beats: 0, 2, 4 and so on, counted from the window start. `s_ready` is high only on those beats. `s_data[7:0]` appears on `lcd_data` on the beat the word is taken, and `s_data[15:8]` on the next beat.
- R6: `lcd_data` is 0 whenever `lcd_de` is low. `s_valid` and `s_data` have no effect outside the data window.
- R7: If `s_valid` is low on a beat where `s_ready` is high, `lcd_data` is 0 on that beat and the next one, and `underflow` is high from the next clock. A low `s_valid` while `s_ready` is low does not set `underflow`.
- R8: `underflow` stays set until a clock edge samples `clr_underflow` high, and is low after that edge. If a new miss happens at the same edge, the flag stays set.
- R9: When `en` is sampled low, from the next clock `lcd_hs_n` and `lcd_vs_n` are high and `lcd_de` is low. A later enable restarts the raster from its origin, as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable for the raster |
| clr_underflow | input | 1 | Clears the sticky underflow flag |
| s_valid | input | 1 | Pixel word valid |
| s_ready | output | 1 | Pixel word taken this clock |
| s_data | input | 16 | Pixel word, low byte sent first |
| lcd_data | output | 8 | Colour byte to the panel |
| lcd_hs_n | output | 1 | Horizontal sync, active low |
| lcd_vs_n | output | 1 | Vertical sync, active low |
| lcd_de | output | 1 | Data-enable |
| underflow | output | 1 | Sticky stream underflow flag |

## Verification
The bench keeps its own clock index k, which starts at 0 on the edge that samples `en` high. From k alone it works out the level that each sync and `lcd_de` must have in that cycle. The vertical sync follows k directly, and the horizontal position follows k-1. Syncs, data-enable and bytes all come combinationally from registered counters, so they are due in the cycle of the edge that produced them. Underflow is due one clock after the missed beat, and the effect of a clear is due one clock after the edge that samples it. Every output is sampled at the falling edge, half a period after its launching edge. At each sampled handshake the stream driver pushes the expected low and high bytes, or two zero bytes for a miss, into a queue, and the monitor pops one byte for every cycle in which it expects `lcd_de` high.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

  // True when pos lies in [start, start+len).
  function automatic logic in_window(input int pos, input int start, input int len);
    return (pos >= start) && (pos < start + len);
  endfunction

  // Even beats of the data window carry a fresh word (low byte).
  function automatic logic word_beat(input int pos, input int start);
    return ((pos - start) % 2) == 0;
  endfunction

endpackage

// File: rtl/lcd_raster_ctr.sv
module lcd_raster_ctr #(
  parameter int PERIOD = 1224,
  parameter int LINES  = 241,
  parameter int PW     = 11,
  parameter int LW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] pos,
  output logic [LW-1:0] line
);
  localparam logic [PW-1:0] POS_LAST  = PW'(PERIOD - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos  <= '0;
      line <= '0;
    end else if (!run) begin
      pos  <= '0;
      line <= '0;
    end else if (pos == POS_LAST) begin
      pos  <= '0;
      line <= (line == LINE_LAST) ? '0 : line + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_byte_unpack.sv
module lcd_byte_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic        clr,
  input  logic        s_valid,
  input  logic [15:0] s_data,
  output logic        s_ready,
  output logic [7:0]  byte_out,
  output logic        miss,
  output logic        hi_phase,
  output logic        flag
);
  logic [7:0] hi_q;
  logic       hi_ok;

  assign s_ready  = beat && !hi_phase;
  assign miss     = s_ready && !s_valid;
  assign byte_out = !beat    ? 8'h00 :
                    hi_phase ? (hi_ok ? hi_q : 8'h00) :
                    (s_valid ? s_data[7:0] : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_phase <= 1'b0;
      hi_q     <= '0;
      hi_ok    <= 1'b0;
      flag     <= 1'b0;
    end else begin
      hi_phase <= beat ? !hi_phase : 1'b0;
      if (s_ready) begin
        hi_q  <= s_data[15:8];
        hi_ok <= s_valid;
      end
      if (miss)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_serial_tgen.sv
module lcd_serial_tgen #(
  parameter int CLK_PER_PIX  = 3,
  parameter int ACT_PIX      = 320,
  parameter int LINE_PIX     = 408,
  parameter int HS_CLKS      = 90,
  parameter int DATA_DELAY   = 204,
  parameter int BLANK_LINES  = 1,
  parameter int ACTIVE_LINES = 240,
  parameter int VS_LINES     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic        clr_underflow,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [15:0] s_data,
  output logic [7:0]  lcd_data,
  output logic        lcd_hs_n,
  output logic        lcd_vs_n,
  output logic        lcd_de,
  output logic        underflow
);
  import lcd_tgen_pkg::*;

  localparam int HTOT     = LINE_PIX * CLK_PER_PIX;
  localparam int ACT_CLKS = ACT_PIX * CLK_PER_PIX;
  localparam int NLINES   = BLANK_LINES + ACTIVE_LINES;
  localparam int PW       = $clog2(HTOT);
  localparam int LW       = $clog2(NLINES + 1);

  logic          v_run, h_run;
  logic [PW-1:0] hpos, vpos;
  logic [LW-1:0] hline, vline;
  logic          hs_pulse, vs_pulse, line_act, win;
  logic          miss, hi_phase;

  // Vertical counter starts first; horizontal one clock later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_run <= 1'b0;
      h_run <= 1'b0;
    end else begin
      v_run <= en;
      h_run <= v_run && en;
    end
  end

  lcd_raster_ctr #(.PERIOD(HTOT), .LINES(NLINES), .PW(PW), .LW(LW)) u_vctr (
    .clk(clk), .rst_n(rst_n), .run(v_run), .pos(vpos), .line(vline));

  lcd_raster_ctr #(.PERIOD(HTOT), .LINES(NLINES), .PW(PW), .LW(LW)) u_hctr (
    .clk(clk), .rst_n(rst_n), .run(h_run), .pos(hpos), .line(hline));

  assign hs_pulse = h_run && (int'(hpos) < HS_CLKS);
  assign vs_pulse = v_run && (int'(vline) < VS_LINES);
  assign line_act = int'(hline) >= BLANK_LINES;
  assign win      = h_run && line_act && in_window(int'(hpos), DATA_DELAY, ACT_CLKS);

  lcd_byte_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .beat(win), .clr(clr_underflow),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .byte_out(lcd_data), .miss(miss), .hi_phase(hi_phase), .flag(underflow));

  assign lcd_hs_n = !hs_pulse;
  assign lcd_vs_n = !vs_pulse;
  assign lcd_de   = win;
endmodule

// File: rtl/lcd_serial_tgen_chk.sv
module lcd_serial_tgen_chk #(
  parameter int BLANK_LINES = 1,
  parameter int HS_CLKS     = 90,
  parameter int LW          = 8,
  parameter int PW          = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          clr_underflow,
  input logic          s_valid,
  input logic          s_ready,
  input logic [7:0]    lcd_data,
  input logic          lcd_hs_n,
  input logic          lcd_vs_n,
  input logic          lcd_de,
  input logic          underflow,
  input logic          h_run,
  input logic [PW-1:0] hpos,
  input logic [LW-1:0] hline
);
  a_r1_vs_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_run) |-> (!lcd_vs_n && $past(!lcd_vs_n) && $past(lcd_hs_n)));

  a_r2_hs_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (h_run && int'(hpos) == HS_CLKS && $past(h_run)) |-> (lcd_hs_n && $past(!lcd_hs_n)));

  a_r4_de_line: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_de |-> (int'(hline) >= BLANK_LINES && lcd_hs_n));

  a_r5_ready_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> lcd_de);

  a_r6_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_de |-> (lcd_data == 8'h00));

  a_r7_miss_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> underflow);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !clr_underflow) |=> underflow);

  a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (lcd_hs_n && lcd_vs_n && !lcd_de));
endmodule

bind lcd_serial_tgen lcd_serial_tgen_chk #(
  .BLANK_LINES(BLANK_LINES), .HS_CLKS(HS_CLKS), .LW(LW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr_underflow(clr_underflow),
  .s_valid(s_valid), .s_ready(s_ready), .lcd_data(lcd_data),
  .lcd_hs_n(lcd_hs_n), .lcd_vs_n(lcd_vs_n), .lcd_de(lcd_de),
  .underflow(underflow), .h_run(h_run), .hpos(hpos), .hline(hline));

// File: tb/lcd_serial_tgen_tb.sv
module lcd_serial_tgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CPP = 3, APIX = 4, LPIX = 10, HSW = 5, DLY = 8;
  localparam int BL = 1, AL = 3, VSL = 2;
  localparam int HTOT  = LPIX * CPP;
  localparam int ACT   = APIX * CPP;
  localparam int NL    = BL + AL;
  localparam int FRAME = NL * HTOT;
  localparam int GAP_K  = FRAME + 1 + HTOT + DLY + 2;      // word beat, line 1
  localparam int IDLE_K = FRAME + 1 + DLY + 1;             // blank line 0
  localparam int CLR_K  = GAP_K + 14;
  localparam int GAP3_K = FRAME + 1 + 2 * HTOT + DLY + 4;  // miss + clear together
  localparam int CLR2_K = GAP3_K + 7;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, clr = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [15:0] s_data = 16'h1a2b;
  logic [7:0] lcd_data;
  logic hs_n, vs_n, de, underflow;

  int checks = 0, errors = 0;
  int k = -1;
  bit und_exp = 1'b0;
  bit accepted = 1'b0;
  bit done = 1'b0;
  logic [7:0] expq[$];

  always #(CLK_PERIOD / 2) clk = !clk;

  lcd_serial_tgen #(
    .CLK_PER_PIX(CPP), .ACT_PIX(APIX), .LINE_PIX(LPIX), .HS_CLKS(HSW),
    .DATA_DELAY(DLY), .BLANK_LINES(BL), .ACTIVE_LINES(AL), .VS_LINES(VSL)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .clr_underflow(clr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .lcd_data(lcd_data), .lcd_hs_n(hs_n), .lcd_vs_n(vs_n),
    .lcd_de(de), .underflow(underflow));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %0h expected %0h", req, k, act, exp);
    end
  endtask

  function automatic bit m_vs(input int kk);
    return kk >= 0 && (kk % FRAME) < VSL * HTOT;
  endfunction
  function automatic bit m_hs(input int kk);
    return kk >= 1 && ((kk - 1) % HTOT) < HSW;
  endfunction
  function automatic bit m_de(input int kk);
    int hc, ln;
    if (kk < 1) return 1'b0;
    hc = (kk - 1) % HTOT;
    ln = ((kk - 1) / HTOT) % NL;
    return ln >= BL && hc >= DLY && hc < DLY + ACT;
  endfunction
  function automatic bit m_rdy(input int kk);
    return m_de(kk) && ((((kk - 1) % HTOT) - DLY) % 2 == 0);
  endfunction

  // Model state advances at the edge.
  always @(posedge clk) begin
    if (rst_n) begin
      if (k >= 0 && m_rdy(k) && !s_valid) und_exp = 1'b1;
      else if (clr) und_exp = 1'b0;
      k = en ? k + 1 : -1;
    end
  end

  // Driver: stream source and scheduled stimuli.
  always @(posedge clk) begin
    #1;
    if (accepted) s_data <= s_data + 16'h1357;
    s_valid <= rst_n && !(k == GAP_K || k == IDLE_K || k == GAP3_K);
    clr     <= (k == CLR_K || k == GAP3_K || k == CLR2_K);
  end

  // Monitor: sample away from the active edge.
  always @(negedge clk) begin
    accepted = 1'b0;
    if (rst_n) begin
      if (k < 0) expq.delete();
      check(hs_n == !m_hs(k), "R2 hs_n", int'(hs_n), int'(!m_hs(k)));
      check(vs_n == !m_vs(k), "R3 vs_n", int'(vs_n), int'(!m_vs(k)));
      check(de == m_de(k), "R4 de", int'(de), int'(m_de(k)));
      check(s_ready == m_rdy(k), "R5 s_ready", int'(s_ready), int'(m_rdy(k)));
      check(underflow == und_exp, "R7/R8 underflow", int'(underflow), int'(und_exp));
      if (m_rdy(k)) begin
        if (s_valid) begin
          expq.push_back(s_data[7:0]);
          expq.push_back(s_data[15:8]);
          accepted = 1'b1;
        end else begin
          expq.push_back(8'h00);
          expq.push_back(8'h00);
        end
      end
      if (m_de(k)) begin
        if (expq.size() == 0) check(1'b0, "R5 queue empty", int'(lcd_data), 0);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          check(lcd_data == e, "R5/R7 lcd_data", int'(lcd_data), int'(e));
        end
      end else begin
        check(lcd_data == 8'h00, "R6 idle data", int'(lcd_data), 0);
      end
      if (k == 0) check(!vs_n && hs_n, "R1 vs leads", int'({vs_n, hs_n}), 1);
      if (k == 1) check(!vs_n && !hs_n, "R1 hs follows", int'({vs_n, hs_n}), 0);
      if (k == IDLE_K + 1) check(!underflow, "R7 no set outside ready", int'(underflow), 0);
      if (k == GAP_K + 1) check(underflow, "R7 flag set", int'(underflow), 1);
      if (k == CLR_K + 1) check(!underflow, "R8 cleared", int'(underflow), 0);
      if (k == GAP3_K + 1) check(underflow, "R8 set wins", int'(underflow), 1);
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(hs_n && vs_n && !de && lcd_data == 0 && !underflow && !s_ready,
          "R9 reset idle", int'({hs_n, vs_n, de}), 3'b110);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 en = 1'b1;
    wait (k == 2 * FRAME + 31);
    @(posedge clk);
    #1 en = 1'b0;
    @(posedge clk);
    #2;
    check(hs_n && vs_n && !de, "R9 stop idle", int'({hs_n, vs_n, de}), 3'b110);
    repeat (5) @(posedge clk);
    #1 en = 1'b1;
    wait (k == FRAME + 10);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule